// File: doc/BRIEF.md
# Pipelined Hessian Determinant Calculator

This block turns three second-order box-filter responses taken at one scale (the horizontal term, the vertical term and the mixed term) into the blob-strength figure used by an interest point detector. Each response is first divided by the filter area. The division is done as a multiply by a constant reciprocal that is fixed when the block is built. The mixed term is then weighted by 0.9. The block computes the product of the two pure terms and subtracts the square of the weighted mixed term.

The datapath is a five-stage register pipeline. A new triple of responses can enter on every clock, and its result leaves exactly five clocks later together with a copy of the input valid flag. All intermediate products keep their full width. Precision is reduced only once, at the last stage: the low fraction bits are dropped by truncation toward minus infinity, and the result saturates to the signed 32-bit output range.

Top module: `hessian_det_pipe`

## Requirements
- R1: For a valid input triple (a = horizontal, b = vertical, c = mixed; each a signed two's-complement 32-bit word with 16 fraction bits), the output is the real value a·K·b·K − (c·K·W)², where K = round(65536/(FILT_N²))/65536 (K = 809/65536 for FILT_N = 9) and W = 58982/65536. It is encoded as a signed 32-bit word with 16 fraction bits.
- R2: `det_valid` equals `resp_valid` delayed by exactly 5 clock edges, and `det_out` belongs to the triple that was accepted 5 edges earlier.
- R3: Triples presented on consecutive clocks each produce their own correct result on consecutive clocks, with no stall or gap.
- R4: Results above 0x7FFFFFFF are replaced by 0x7FFFFFFF, and results below 0x80000000 (as signed) are replaced by 0x80000000.
- R5: Whenever `det_valid` is low, `det_out` is 0.
- R6: While `rst_n` is low, `det_valid` and `det_out` are 0.
- R7: Bits below the 16 output fraction bits are dropped by rounding toward minus infinity. A result that is negative but smaller in magnitude than 2⁻¹⁶ therefore reads 0xFFFFFFFF.
- R8: Response values presented while `resp_valid` is low produce no valid output: 5 edges later `det_valid` is 0 and `det_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| resp_valid | input | 1 | The three responses are valid this cycle |
| resp_xx | input | 32 | Horizontal second-derivative response, signed, 16 fraction bits |
| resp_yy | input | 32 | Vertical second-derivative response, signed, 16 fraction bits |
| resp_xy | input | 32 | Mixed second-derivative response, signed, 16 fraction bits |
| det_valid | output | 1 | `det_out` holds a result |
| det_out | output | 32 | Normalised determinant, signed, 16 fraction bits |

## Verification
Random triples of small magnitude stay inside the output range. They test the exact arithmetic of R1, including the reciprocal constant and the 0.9 weight. Random full-range triples mostly saturate, in both directions, and so separate correct clamping from wrap-around. Directed cases each isolate one term: a pure square of the mixed term, a pure product of the pure terms, all zero, and a tiny negative result that shows floor truncation as opposed to truncation toward zero. Unbroken bursts test R3. Gaps filled with garbage responses while the valid flag is low test R8 and the zero output of R5.

// File: rtl/hd_pkg.sv
package hd_pkg;

  localparam int LANE_XX = 0;
  localparam int LANE_YY = 1;
  localparam int LANE_XY = 2;
  localparam int LANES   = 3;

  // reciprocal of the filter area, rounded to frac bits
  function automatic int unsigned inv_area_q(input int unsigned n, input int unsigned frac);
    int unsigned area;
    area = n * n;
    return ((32'd1 << frac) + area / 2) / area;
  endfunction

  // 0.9 rounded to frac bits
  function automatic int unsigned weight_q(input int unsigned frac);
    return ((32'd9 << frac) + 32'd5) / 32'd10;
  endfunction

endpackage

// File: rtl/hd_normalize.sv
module hd_normalize #(
  parameter int IN_W = 32,
  parameter int K_W  = 17,
  parameter int N_W  = 49,
  parameter logic [K_W-1:0] INV_K = '0
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            vld_i,
  input  logic [hd_pkg::LANES-1:0][IN_W-1:0] resp_i,
  output logic                            vld_o,
  output logic [hd_pkg::LANES-1:0][N_W-1:0]  nrm_o
);

  function automatic logic signed [N_W-1:0] scale(input logic signed [IN_W-1:0] v,
                                                  input logic [K_W-1:0] k);
    logic signed [N_W-1:0] ve;
    logic signed [N_W-1:0] ke;
    ve = v;
    ke = $signed({1'b0, k});
    return ve * ke;
  endfunction

  logic vld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_i;
  end
  assign vld_o = vld_q;

  for (genvar g = 0; g < hd_pkg::LANES; g++) begin : g_lane
    logic signed [N_W-1:0] nrm_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) nrm_q <= '0;
      else        nrm_q <= scale($signed(resp_i[g]), INV_K);
    end
    assign nrm_o[g] = nrm_q;

    // a zero response stays zero after normalisation
    assert_zero_norm_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_i && resp_i[g] == '0) |=> (nrm_q == '0));
  end

  assert_norm_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |-> $past(vld_i));

endmodule

// File: rtl/hd_product.sv
module hd_product #(
  parameter int N_W  = 49,
  parameter int K_W  = 17,
  parameter int P_W  = 98,
  parameter int WX_W = 66,
  parameter int SQ_W = 132,
  parameter logic [K_W-1:0] W_K = '0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   vld_i,
  input  logic signed [N_W-1:0]  nxx_i,
  input  logic signed [N_W-1:0]  nyy_i,
  input  logic signed [N_W-1:0]  nxy_i,
  output logic                   vld_o,
  output logic signed [P_W-1:0]  prod_o,
  output logic signed [SQ_W-1:0] sq_o
);

  function automatic logic signed [P_W-1:0] mul_pure(input logic signed [N_W-1:0] a,
                                                     input logic signed [N_W-1:0] b);
    logic signed [P_W-1:0] ae;
    logic signed [P_W-1:0] be;
    ae = a;
    be = b;
    return ae * be;
  endfunction

  function automatic logic signed [WX_W-1:0] weigh(input logic signed [N_W-1:0] a,
                                                   input logic [K_W-1:0] w);
    logic signed [WX_W-1:0] ae;
    logic signed [WX_W-1:0] we;
    ae = a;
    we = $signed({1'b0, w});
    return ae * we;
  endfunction

  function automatic logic signed [SQ_W-1:0] square(input logic signed [WX_W-1:0] a);
    logic signed [SQ_W-1:0] ae;
    ae = a;
    return ae * ae;
  endfunction

  // stage A: pure product and weighted cross term
  logic                   vld_a;
  logic signed [P_W-1:0]  prod_a;
  logic signed [WX_W-1:0] wx_a;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_a  <= 1'b0;
      prod_a <= '0;
      wx_a   <= '0;
    end else begin
      vld_a  <= vld_i;
      prod_a <= mul_pure(nxx_i, nyy_i);
      wx_a   <= weigh(nxy_i, W_K);
    end
  end

  // stage B: square of the weighted cross term
  logic                   vld_b;
  logic signed [P_W-1:0]  prod_b;
  logic signed [SQ_W-1:0] sq_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_b  <= 1'b0;
      prod_b <= '0;
      sq_b   <= '0;
    end else begin
      vld_b  <= vld_a;
      prod_b <= prod_a;
      sq_b   <= square(wx_a);
    end
  end

  assign vld_o  = vld_b;
  assign prod_o = prod_b;
  assign sq_o   = sq_b;

  // the cross term is squared, so it can never become negative
  assert_square_nonneg_R1: assert property (@(posedge clk) disable iff (!rst_n)
    vld_b |-> !sq_b[SQ_W-1]);

  assert_prod_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    vld_b |-> $past(vld_a));

  assert_stage_a_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    vld_a |-> $past(vld_i));

endmodule

// File: rtl/hd_combine.sv
module hd_combine #(
  parameter int P_W     = 98,
  parameter int SQ_W    = 132,
  parameter int ALIGN   = 32,
  parameter int SHIFT   = 80,
  parameter int OUT_W   = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    vld_i,
  input  logic signed [P_W-1:0]   prod_i,
  input  logic signed [SQ_W-1:0]  sq_i,
  output logic                    vld_o,
  output logic signed [OUT_W-1:0] det_o
);

  localparam int PA_W = P_W + ALIGN;
  localparam int D_W  = ((PA_W > SQ_W) ? PA_W : SQ_W) + 1;
  localparam logic signed [D_W-1:0] MAXV = D_W'({1'b0, {(OUT_W-1){1'b1}}});
  localparam logic signed [D_W-1:0] MINV = ~MAXV;
  localparam logic signed [OUT_W-1:0] OUT_MAX = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic signed [OUT_W-1:0] OUT_MIN = {1'b1, {(OUT_W-1){1'b0}}};

  function automatic logic signed [D_W-1:0] difference(input logic signed [P_W-1:0] p,
                                                       input logic signed [SQ_W-1:0] s);
    logic signed [D_W-1:0] pe;
    logic signed [D_W-1:0] se;
    pe = p;
    se = s;
    return (pe <<< ALIGN) - se;
  endfunction

  // stage C: aligned subtraction at full precision
  logic                  vld_c;
  logic signed [D_W-1:0] diff_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_c  <= 1'b0;
      diff_c <= '0;
    end else begin
      vld_c  <= vld_i;
      diff_c <= difference(prod_i, sq_i);
    end
  end

  // floor truncation and range detection
  logic signed [D_W-1:0] trunc_c;
  logic                  sat_hi;
  logic                  sat_lo;
  assign trunc_c = diff_c >>> SHIFT;
  assign sat_hi  = trunc_c > MAXV;
  assign sat_lo  = trunc_c < MINV;

  // stage D: output register
  logic                    vld_d;
  logic signed [OUT_W-1:0] det_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_d <= 1'b0;
      det_d <= '0;
    end else begin
      vld_d <= vld_c;
      if (!vld_c)      det_d <= '0;
      else if (sat_hi) det_d <= OUT_MAX;
      else if (sat_lo) det_d <= OUT_MIN;
      else             det_d <= trunc_c[OUT_W-1:0];
    end
  end

  assign vld_o = vld_d;
  assign det_o = det_d;

  assert_sat_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_c && sat_hi) |=> (det_d == OUT_MAX));

  assert_sat_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_c && sat_lo) |=> (det_d == OUT_MIN));

  assert_idle_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_d |-> (det_d == '0));

  assert_floor_sign_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_c && !sat_lo && diff_c < 0) |=> det_d[OUT_W-1]);

  assert_out_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    vld_d |-> $past(vld_c));

endmodule

// File: rtl/hessian_det_pipe.sv
module hessian_det_pipe #(
  parameter int FILT_N   = 9,
  parameter int IN_W     = 32,
  parameter int IN_FRAC  = 16,
  parameter int K_W      = 17,
  parameter int K_FRAC   = 16,
  parameter int OUT_W    = 32,
  parameter int OUT_FRAC = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            resp_valid,
  input  logic [IN_W-1:0] resp_xx,
  input  logic [IN_W-1:0] resp_yy,
  input  logic [IN_W-1:0] resp_xy,
  output logic            det_valid,
  output logic [OUT_W-1:0] det_out
);

  import hd_pkg::*;

  localparam logic [K_W-1:0] INV_K = K_W'(inv_area_q(FILT_N, K_FRAC));
  localparam logic [K_W-1:0] W_K   = K_W'(weight_q(K_FRAC));

  localparam int N_W     = IN_W + K_W;
  localparam int N_FRAC  = IN_FRAC + K_FRAC;
  localparam int P_W     = 2 * N_W;
  localparam int P_FRAC  = 2 * N_FRAC;
  localparam int WX_W    = N_W + K_W;
  localparam int WX_FRAC = N_FRAC + K_FRAC;
  localparam int SQ_W    = 2 * WX_W;
  localparam int SQ_FRAC = 2 * WX_FRAC;
  localparam int ALIGN   = SQ_FRAC - P_FRAC;
  localparam int SHIFT   = SQ_FRAC - OUT_FRAC;
  localparam int LAT     = 5;

  logic [LANES-1:0][IN_W-1:0] resp_pack;
  assign resp_pack[LANE_XX] = resp_xx;
  assign resp_pack[LANE_YY] = resp_yy;
  assign resp_pack[LANE_XY] = resp_xy;

  logic                     norm_vld;
  logic [LANES-1:0][N_W-1:0] norm_val;

  hd_normalize #(.IN_W(IN_W), .K_W(K_W), .N_W(N_W), .INV_K(INV_K)) u_norm (
    .clk    (clk),
    .rst_n  (rst_n),
    .vld_i  (resp_valid),
    .resp_i (resp_pack),
    .vld_o  (norm_vld),
    .nrm_o  (norm_val)
  );

  logic                   prod_vld;
  logic signed [P_W-1:0]  prod_val;
  logic signed [SQ_W-1:0] sq_val;

  hd_product #(.N_W(N_W), .K_W(K_W), .P_W(P_W), .WX_W(WX_W), .SQ_W(SQ_W), .W_K(W_K)) u_prod (
    .clk    (clk),
    .rst_n  (rst_n),
    .vld_i  (norm_vld),
    .nxx_i  ($signed(norm_val[LANE_XX])),
    .nyy_i  ($signed(norm_val[LANE_YY])),
    .nxy_i  ($signed(norm_val[LANE_XY])),
    .vld_o  (prod_vld),
    .prod_o (prod_val),
    .sq_o   (sq_val)
  );

  logic                    comb_vld;
  logic signed [OUT_W-1:0] comb_det;

  hd_combine #(.P_W(P_W), .SQ_W(SQ_W), .ALIGN(ALIGN), .SHIFT(SHIFT), .OUT_W(OUT_W)) u_comb (
    .clk    (clk),
    .rst_n  (rst_n),
    .vld_i  (prod_vld),
    .prod_i (prod_val),
    .sq_i   (sq_val),
    .vld_o  (comb_vld),
    .det_o  (comb_det)
  );

  assign det_valid = comb_vld;
  assign det_out   = comb_det;

  // latency check via a shift of the input flag, counted against cycles since reset
  logic [LAT-1:0] vld_hist;
  logic [2:0]     since_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_hist  <= '0;
      since_rst <= '0;
    end else begin
      vld_hist  <= {vld_hist[LAT-2:0], resp_valid};
      if (since_rst != 3'(LAT)) since_rst <= since_rst + 3'd1;
    end
  end

  assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 3'(LAT)) |-> (det_valid == vld_hist[LAT-1]));

  assert_reset_quiet_R6: assert property (@(posedge clk)
    !rst_n |-> (!det_valid && det_out == '0));

endmodule

// File: tb/hessian_det_pipe_test.sv
module hessian_det_pipe_test;

  localparam int LAT = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        resp_valid = 1'b0;
  logic [31:0] resp_xx = '0;
  logic [31:0] resp_yy = '0;
  logic [31:0] resp_xy = '0;
  logic        det_valid;
  logic [31:0] det_out;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  hessian_det_pipe uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .resp_valid (resp_valid),
    .resp_xx    (resp_xx),
    .resp_yy    (resp_yy),
    .resp_xy    (resp_xy),
    .det_valid  (det_valid),
    .det_out    (det_out)
  );

  // reference arithmetic from the requirement, scaled by 2^96 and floored
  function automatic logic [31:0] ref_det(input logic [31:0] a, input logic [31:0] b,
                                          input logic [31:0] c);
    logic signed [199:0] ka, kb, kc, kk, ww, lhs, rhs, v;
    kk = 200'($rtoi(65536.0 / 81.0 + 0.5));
    ww = 200'($rtoi(0.9 * 65536.0 + 0.5));
    ka = $signed(a);
    kb = $signed(b);
    kc = $signed(c);
    lhs = (ka * kk) * (kb * kk);
    lhs = lhs * 200'(64'h1_0000_0000);
    rhs = kc * kk * ww;
    rhs = rhs * rhs;
    v = (lhs - rhs) >>> 80;
    if (v > 200'sh7FFF_FFFF) return 32'h7FFF_FFFF;
    if (v < -200'sh8000_0000) return 32'h8000_0000;
    return v[31:0];
  endfunction

  logic        hv   [LAT];
  logic [31:0] hexp [LAT];
  string       htag [LAT];

  initial begin
    for (int i = 0; i < LAT; i++) begin
      hv[i] = 1'b0; hexp[i] = '0; htag[i] = "R5";
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one clock: compare what is due, then drive the next input at the falling edge
  task automatic step(input logic v, input logic [31:0] a, input logic [31:0] b,
                      input logic [31:0] c, input string tag);
    @(negedge clk);
    if (hv[LAT-1]) begin
      check("R2 valid", 32'(det_valid), 32'd1);
      check(htag[LAT-1], det_out, hexp[LAT-1]);
    end else begin
      check({htag[LAT-1], " valid"}, 32'(det_valid), 32'd0);
      check(htag[LAT-1], det_out, 32'd0);
    end
    for (int i = LAT - 1; i > 0; i--) begin
      hv[i] = hv[i-1]; hexp[i] = hexp[i-1]; htag[i] = htag[i-1];
    end
    hv[0] = v;
    hexp[0] = v ? ref_det(a, b, c) : 32'd0;
    htag[0] = tag;
    resp_valid = v; resp_xx = a; resp_yy = b; resp_xy = c;
  endtask

  function automatic logic [31:0] small_val();
    logic [31:0] r;
    r = $urandom;
    return $signed(r) >>> 12;
  endfunction

  initial begin
    #2_000_000;
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    // R6: quiet outputs while reset is held
    repeat (3) @(negedge clk);
    check("R6 valid", 32'(det_valid), 32'd0);
    check("R6 det", det_out, 32'd0);
    rst_n = 1'b1;

    // directed corner cases
    step(1'b1, 32'h0, 32'h0, 32'h0, "R1 zero");
    step(1'b1, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 32'h0, "R4 high");
    step(1'b1, 32'h0, 32'h0, 32'h7FFF_FFFF, "R4 low");
    step(1'b1, 32'h0, 32'h0, 32'h1, "R7 floor");
    step(1'b1, 32'h0001_0000, 32'h0001_0000, 32'h0, "R1 unit");
    step(1'b1, 32'h0010_0000, 32'hFFF0_0000, 32'h0, "R1 neg product");
    step(1'b1, 32'h0, 32'h0, 32'h0080_0000, "R1 cross only");
    step(1'b0, 32'hDEAD_BEEF, 32'h1234_5678, 32'h8765_4321, "R8");
    step(1'b0, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 32'h0, "R8");

    // R3: unbroken burst of in-range random triples
    for (int i = 0; i < 300; i++)
      step(1'b1, small_val(), small_val(), small_val(), "R3");

    // R1 with gaps carrying garbage, R8 on the gaps
    for (int i = 0; i < 400; i++) begin
      if ($urandom_range(0, 3) == 0)
        step(1'b0, $urandom, $urandom, $urandom, "R8");
      else
        step(1'b1, small_val(), small_val(), small_val(), "R1");
    end

    // R4: full-range random triples, most saturate
    for (int i = 0; i < 200; i++)
      step(1'b1, $urandom, $urandom, $urandom, "R4");

    // flush the pipeline
    for (int i = 0; i < LAT + 1; i++)
      step(1'b0, 32'h0, 32'h0, 32'h0, "R5");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule